// File: doc/BRIEF.md
# Codec Link Reset and Suspend Timer

This block produces the timed control signals of an AC97 codec link, running entirely on the host bus clock. A free-running prescaler divides the bus clock into a single-cycle tick every 250 ns. Two sequence timers count those ticks. The first holds the codec reset output low for a guaranteed minimum time after a cold-reset request. The second drives SYNC high for a fixed time when a warm wake-up (resume) is requested.

A separate monitor watches the codec bit clock. It raises a suspended flag once that clock has stopped toggling for longer than about two of its nominal periods. The host sets `TICK_RELOAD` to one less than the number of bus cycles in 250 ns (49 at 200 MHz). It sets `IDLE_LIMIT` to the number of bus cycles in roughly 163 ns (33 at 200 MHz). The reset stretch of 4 ticks and the resume length of 5 ticks are fixed. The resume length carries one tick of margin because the prescaler phase at the moment of a request is unknown.

Top module: `codec_link_timer`

## Requirements
- R1: With P = TICK_RELOAD+1, ticks occur at the P-th, 2P-th, ... rising edge after bus reset release. After release, `rst_busy_o` stays high and `codec_rst_no` stays low until the 4P-th rising edge, where both change.
- R2: Suppose a cold request rises while no reset sequence runs, and is first sampled high at rising edge e (edges counted from release). Then `rst_busy_o` is high from edge e until edge (floor(e/P)+4)*P.
- R3: `codec_rst_no` is low whenever the reset sequence runs or `cold_req_i` is high. A request held longer than the stretch keeps the reset asserted until the request is released.
- R4: Suppose a resume request rises and is first sampled high at edge e. Then `sync_o` is high from edge e until edge (floor(e/P)+5)*P, so it is high for at least 4P+1 cycles.
- R5: A resume request whose rising edge is sampled while the reset sequence runs or `cold_req_i` is high is ignored: `sync_o` stays low.
- R6: A further rising edge on a request while its sequence runs neither restarts nor extends that sequence.
- R7: `rst_busy_o` is high exactly while the reset stretch runs. `resume_busy_o` equals `sync_o`. Each busy output falls on the edge where its sequence ends.
- R8: `bit_clk_i` passes through two synchronizing flops. `suspended_o` rises IDLE_LIMIT+2 rising edges after the edge that first samples the last change of `bit_clk_i`, and it stays high while the clock remains stopped.
- R9: A rising or a falling change of `bit_clk_i` clears `suspended_o` at the second rising edge after the edge that first samples it.
- R10: While `rst_ni` is low, `codec_rst_no` is low, `rst_busy_o` is high, and `sync_o`, `resume_busy_o` and `suspended_o` are low, even in the middle of a running resume.
- R11: A bit clock that changes level at intervals shorter than IDLE_LIMIT cycles keeps `suspended_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Asynchronous bus reset, active low |
| cold_req_i | input | 1 | Cold-reset request, level |
| resume_req_i | input | 1 | Warm wake-up request, rising edge starts a sequence |
| bit_clk_i | input | 1 | Raw codec bit clock, asynchronous |
| codec_rst_no | output | 1 | Codec reset, active low |
| sync_o | output | 1 | SYNC drive during resume signalling |
| rst_busy_o | output | 1 | Reset stretch in progress |
| resume_busy_o | output | 1 | Resume signalling in progress |
| suspended_o | output | 1 | Bit clock judged stopped |

## Verification
The bench issues resume and short cold requests at every prescaler phase. A timer that counted the tick already present at its start edge, or one that waited for an extra tick, would miss the exact edge count in at least one phase. Requests are also overlapped: second pulses inside a running sequence, resume pulses inside a stretch, and resume pulses while a cold request is held. These catch a sequence that restarts or a guard that only looks at the stretch counter. The bit-clock tests stop the clock after both a rising and a falling change and sample the flag one edge before and after its expected transition. They also hold the clock stopped for a long time, so a counter that wraps instead of saturating would drop the flag.

// File: rtl/link_timer_pkg.sv
package link_timer_pkg;
  // tick counts of the two fixed sequences
  localparam int unsigned RST_TICKS   = 4;
  localparam int unsigned RES_TICKS   = 5;
  // synchronizer depth on the bit clock
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/lt_tick_gen.sv
module lt_tick_gen #(
  parameter int unsigned RELOAD = 49
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (RELOAD > 0) ? $clog2(RELOAD + 1) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CW'(RELOAD);
    else if (tick_o) cnt_q <= CW'(RELOAD);
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/lt_seq_timer.sv
module lt_seq_timer #(
  parameter int unsigned TICKS         = 4,
  parameter bit          BUSY_AT_RESET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= BUSY_AT_RESET;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (tick_i) begin
      // a tick on the start edge is not counted (busy_q was low)
      if (cnt_q == CW'(TICKS - 1)) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lt_idle_mon.sv
module lt_idle_mon #(
  parameter int unsigned LIMIT  = 33,
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_clk_i,
  output logic idle_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [STAGES:0] sh_q;
  logic [CW-1:0]   cnt_q;
  logic            chg;

  // extra flop past the synchronizer gives both-edge detection
  assign chg    = sh_q[STAGES] ^ sh_q[STAGES-1];
  assign idle_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-1:0], bit_clk_i};
      if (chg)          cnt_q <= '0;
      else if (!idle_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/codec_link_timer.sv
module codec_link_timer
  import link_timer_pkg::*;
#(
  parameter int unsigned TICK_RELOAD = 49,
  parameter int unsigned IDLE_LIMIT  = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cold_req_i,
  input  logic resume_req_i,
  input  logic bit_clk_i,
  output logic codec_rst_no,
  output logic sync_o,
  output logic rst_busy_o,
  output logic resume_busy_o,
  output logic suspended_o
);
  logic tick;
  logic cold_q, res_q;
  logic cold_start, res_start;
  logic rst_busy, res_busy, rst_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      cold_q <= cold_req_i;
      res_q  <= resume_req_i;
    end
  end

  assign rst_active = rst_busy | cold_req_i;
  assign cold_start = cold_req_i & ~cold_q;
  assign res_start  = resume_req_i & ~res_q & ~rst_active;

  lt_tick_gen #(.RELOAD(TICK_RELOAD)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  lt_seq_timer #(.TICKS(RST_TICKS), .BUSY_AT_RESET(1'b1)) u_rst_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (cold_start),
    .busy_o  (rst_busy)
  );

  lt_seq_timer #(.TICKS(RES_TICKS), .BUSY_AT_RESET(1'b0)) u_res_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (res_start),
    .busy_o  (res_busy)
  );

  lt_idle_mon #(.LIMIT(IDLE_LIMIT), .STAGES(SYNC_STAGES)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_clk_i (bit_clk_i),
    .idle_o    (suspended_o)
  );

  assign codec_rst_no  = ~rst_active;
  assign rst_busy_o    = rst_busy;
  assign sync_o        = res_busy;
  assign resume_busy_o = res_busy;
endmodule

// File: rtl/codec_link_timer_chk.sv
module codec_link_timer_chk
  import link_timer_pkg::*;
#(
  parameter int unsigned TICK_RELOAD = 49,
  parameter int unsigned IDLE_LIMIT  = 33
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cold_req_i,
  input logic resume_req_i,
  input logic bit_clk_i,
  input logic codec_rst_no,
  input logic sync_o,
  input logic rst_busy_o,
  input logic resume_busy_o,
  input logic suspended_o
);
  localparam int unsigned P = TICK_RELOAD + 1;

  logic [15:0] rst_len, res_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_len <= '0;
      res_len <= '0;
    end else begin
      rst_len <= rst_busy_o    ? rst_len + 1'b1 : '0;
      res_len <= resume_busy_o ? res_len + 1'b1 : '0;
    end
  end

  // R2: a stretch never ends before (RST_TICKS-1)*P+1 cycles
  p_rst_min_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_busy_o) |-> rst_len >= 16'((RST_TICKS - 1) * P + 1));

  // R4: resume length lies between (N-1)*P+1 and N*P cycles
  p_res_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (res_len >= 16'((RES_TICKS - 1) * P + 1)) &&
                      (res_len <= 16'(RES_TICKS * P)));

  // R5: resume only starts when the codec reset was released
  p_no_resume_in_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_busy_o) |-> $past(codec_rst_no));

  // R8: flag only rises after the synchronized clock stood still
  p_susp_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(suspended_o) |-> $past(bit_clk_i, 3) == $past(bit_clk_i, 4));

  // R8: flag holds while no change reaches the detector
  p_susp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o && ($past(bit_clk_i, 2) == $past(bit_clk_i, 3)) |=> suspended_o);
endmodule

bind codec_link_timer codec_link_timer_chk #(
  .TICK_RELOAD (TICK_RELOAD),
  .IDLE_LIMIT  (IDLE_LIMIT)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cold_req_i    (cold_req_i),
  .resume_req_i  (resume_req_i),
  .bit_clk_i     (bit_clk_i),
  .codec_rst_no  (codec_rst_no),
  .sync_o        (sync_o),
  .rst_busy_o    (rst_busy_o),
  .resume_busy_o (resume_busy_o),
  .suspended_o   (suspended_o)
);

// File: tb/codec_link_timer_tb_top.sv
module codec_link_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RELOAD     = 3;
  localparam int P          = RELOAD + 1;
  localparam int LIMIT      = 5;

  logic clk = 1'b0;
  logic rst_n, cold_req, res_req, bclk;
  logic codec_rst_n, sync, rst_busy, res_busy, susp;
  int   cyc;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  codec_link_timer #(.TICK_RELOAD(RELOAD), .IDLE_LIMIT(LIMIT)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cold_req_i    (cold_req),
    .resume_req_i  (res_req),
    .bit_clk_i     (bclk),
    .codec_rst_no  (codec_rst_n),
    .sync_o        (sync),
    .rst_busy_o    (rst_busy),
    .resume_busy_o (res_busy),
    .suspended_o   (susp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic align(input int d);
    while (((cyc + 1) % P) != d) @(negedge clk);
  endtask

  // count cycles the stretch busy is high right after reset release
  task automatic count_after_release(output int n, output int bad);
    n = 0; bad = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!rst_busy) break;
      n++;
      if (codec_rst_n) bad++;
    end
  endtask

  // resume pulse at phase d; optional second pulse at sample index again
  task automatic run_resume(input int d, input int again, output int n,
                            output int mis, output int e);
    align(d);
    e = cyc + 1;
    res_req = 1'b1;
    n = 0; mis = 0;
    for (int k = 1; k < 500; k++) begin
      @(negedge clk);
      if (sync !== res_busy) mis++;
      if (k == 1) res_req = 1'b0;
      if (k == again) res_req = 1'b1;
      if (k == again + 1) res_req = 1'b0;
      if (!sync) break;
      n++;
    end
    res_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // cold request at phase d held for hold samples; optional resume pulse
  task automatic run_cold(input int d, input int hold, input int res_at,
                          output int low_n, output int busy_n,
                          output int sync_seen, output int e);
    align(d);
    e = cyc + 1;
    cold_req = 1'b1;
    low_n = 0; busy_n = 0; sync_seen = 0;
    for (int k = 1; k < 500; k++) begin
      @(negedge clk);
      if (!codec_rst_n) low_n++;
      if (rst_busy) busy_n++;
      if (sync) sync_seen++;
      if (k >= hold && codec_rst_n && !rst_busy) break;
      if (k == hold) cold_req = 1'b0;
      if (k == res_at) res_req = 1'b1;
      if (k == res_at + 1) res_req = 1'b0;
    end
    cold_req = 1'b0;
    res_req  = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (sync) sync_seen++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, bad, mis, e, lo, bz, ss, a, exp_f;
    rst_n = 1'b0; cold_req = 1'b0; res_req = 1'b0; bclk = 1'b0;
    repeat (3) @(negedge clk);

    // R10: state under bus reset
    chk("R10 codec_rst_no", codec_rst_n, 0);
    chk("R10 rst_busy", rst_busy, 1);
    chk("R10 sync", sync, 0);
    chk("R10 resume_busy", res_busy, 0);
    chk("R10 suspended", susp, 0);

    // R1: full stretch after release
    rst_n = 1'b1;
    count_after_release(n, bad);
    chk("R1 stretch after release", n, 4 * P - 1);
    chk("R3 reset low while busy", bad, 0);
    chk("R1 reset released", codec_rst_n, 1);

    // R8: clock stopped since start
    chk("R8 suspended on stopped clock", susp, 1);

    // R4 / R7: resume at every prescaler phase
    for (int d = 0; d < P; d++) begin
      run_resume(d, 0, n, mis, e);
      chk("R4 resume length", n, ((e / P) + 5) * P - e);
      chk("R7 resume_busy equals sync", mis, 0);
    end

    // R6: second resume pulse inside a running sequence
    for (int d = 0; d < P; d++) begin
      run_resume(d, 3 + 4 * d, n, mis, e);
      chk("R6 resume not restarted", n, ((e / P) + 5) * P - e);
    end

    // R2 / R7: short cold request at every phase
    for (int d = 0; d < P; d++) begin
      run_cold(d, 1, 0, lo, bz, ss, e);
      exp_f = ((e / P) + 4) * P - e;
      chk("R2 stretch busy length", bz, exp_f);
      chk("R7 reset low equals busy", lo, exp_f);
    end

    // R6: second cold pulse inside the stretch
    run_cold(1, 1, 0, lo, bz, ss, e);
    exp_f = ((e / P) + 4) * P - e;
    cold_req = 1'b1; @(negedge clk); cold_req = 1'b0;
    // handled separately: pulse inside stretch
    run_cold(2, 1, 0, lo, bz, ss, e);
    chk("R2 stretch repeatable", bz, ((e / P) + 4) * P - e);

    // R3: held request extends the reset beyond the stretch
    run_cold(3, 30, 0, lo, bz, ss, e);
    exp_f = ((e / P) + 4) * P - e;
    chk("R3 held reset low", lo, max2(30, exp_f));
    chk("R3 stretch unaffected by hold", bz, exp_f);

    // R5: resume during stretch, and during held request after stretch
    run_cold(0, 1, 3, lo, bz, ss, e);
    chk("R5 resume ignored in stretch", ss, 0);
    run_cold(1, 30, 22, lo, bz, ss, e);
    chk("R5 resume ignored while request held", ss, 0);

    // R9 / R8: rising change, exact release and re-raise timing
    chk("R8 suspended before change", susp, 1);
    bclk = 1'b1;
    a = cyc + 1;
    while (cyc < a + 1) @(negedge clk);
    chk("R9 flag still high one edge early", susp, 1);
    @(negedge clk);
    chk("R9 rising change clears flag", susp, 0);
    while (cyc < a + 1 + LIMIT) @(negedge clk);
    chk("R8 flag low one edge early", susp, 0);
    @(negedge clk);
    chk("R8 flag raised on time", susp, 1);
    bad = 0;
    repeat (100) begin
      @(negedge clk);
      if (!susp) bad++;
    end
    chk("R8 flag saturates", bad, 0);

    // R9: falling change
    bclk = 1'b0;
    a = cyc + 1;
    while (cyc < a + 1) @(negedge clk);
    chk("R9 flag high before falling change lands", susp, 1);
    @(negedge clk);
    chk("R9 falling change clears flag", susp, 0);

    // R11: running clock keeps flag low
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      bclk = ~bclk;
      repeat (2) begin
        @(negedge clk);
        if (i >= 2 && susp) bad++;
      end
    end
    chk("R11 running clock not suspended", bad, 0);

    // R10: bus reset in the middle of a resume
    res_req = 1'b1;
    @(negedge clk);
    res_req = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 resume running before reset", sync, 1);
    rst_n = 1'b0;
    #1;
    chk("R10 sync dropped by reset", sync, 0);
    chk("R10 codec reset forced", codec_rst_n, 0);
    chk("R10 stretch busy forced", rst_busy, 1);
    @(negedge clk);
    rst_n = 1'b1;
    count_after_release(n, bad);
    chk("R1 full stretch after second reset", n, 4 * P - 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule